// File: doc/BRIEF.md
# Fractional clock enable generator

This block turns a fixed base clock into a train of single-cycle enable pulses whose long-run rate is a rational fraction of that clock. Two elaboration-time parameters set the base frequency and the wanted output frequency. Their ratio is reduced by its greatest common divisor to an increment `n` over a modulus `m`. A phase accumulator, starting at zero, adds `n` on every clock edge and wraps at `m`. Each wrap raises the enable for one cycle.

Downstream logic uses the pulse as a clock enable to run at the slower rate. The pulses are spaced as evenly as a whole-cycle grid allows. An active-low asynchronous reset and a synchronous clear both return the block to phase zero. Elaboration stops with an error when the output frequency is zero or exceeds the base frequency.

The design has no state machine. The accumulator value is its only state, and the registered pulse follows from it.

Top module: `frac_enable_gen`

## Requirements
- R1: The increment is `n = OUT_HZ / g` and the modulus is `m = BASE_HZ / g`, where `g` is the greatest common divisor of the two frequencies. With 48 and 18 this gives 3 pulses in every 8 cycles, and the defaults of 100 MHz and 7 MHz give 7 pulses in every 100 cycles.
- R2: While `rst_ni` is low, `pulse_o` is low and the phase is zero. Asserting `rst_ni` low clears the output at once, without waiting for a clock edge.
- R3: The accumulator always stays in the range 0 to m-1. At each clock edge where `srst_i` is low, it advances to (phase + n) mod m, formed with a subtraction rather than a divider.
- R4: Number the clock edges where `srst_i` is low from 1, starting after the last reset or clear. `pulse_o` is high in the cycle after the k-th such edge exactly when floor(k·n/m) > floor((k-1)·n/m), which is the edge where phase + n ≥ m. Each pulse is registered and lasts one cycle.
- R5: While `srst_i` stays low, every run of m consecutive cycles holds exactly n pulses.
- R6: A clock edge with `srst_i` high sets the phase to zero and drives `pulse_o` low in the following cycle. Edge counting as in R4 then starts again from 1.
- R7: When the two frequencies are equal (n = m = 1), `pulse_o` is high in every cycle that follows an edge with `srst_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear of the phase and the pulse, active high |
| pulse_o | output | 1 | One-cycle enable pulse |

## Verification
The hardest case to reach from the ports is a synchronous clear that arrives at an arbitrary phase, and in particular on the very edge where a wrap would have produced a pulse. The pulse must then be suppressed, and the pulse pattern must restart exactly from phase zero. Random clears of random length are scattered over thousands of cycles to reach such cases. Three instances with different reduced ratios run side by side for this. Each cycle is compared with a floor-division model that counts edges since the last clear. Directed runs add long uninterrupted windows to count pulses, plus an asynchronous reset asserted in the middle of a cycle.

// File: rtl/frac_enable_pkg.sv
package frac_enable_pkg;

    // Greatest common divisor, evaluated at elaboration.
    function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Bits needed to hold a phase value in 0 .. m-1 (at least one bit).
    function automatic int unsigned phase_width(input int unsigned m);
        return (m <= 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/frac_phase_accum.sv
module frac_phase_accum #(
    parameter int unsigned INC = 7,
    parameter int unsigned MOD = 100,
    localparam int unsigned W  = frac_enable_pkg::phase_width(MOD)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         srst_i,
    output logic         wrap_o,
    output logic [W-1:0] phase_o
);

    localparam logic [W:0] INC_X = (W+1)'(INC);
    localparam logic [W:0] MOD_X = (W+1)'(MOD);

    logic [W-1:0] phase_q;
    logic [W:0]   sum_x;
    logic [W:0]   next_x;

    // One bit wider than the phase so the sum cannot overflow before the compare.
    always_comb begin
        sum_x  = {1'b0, phase_q} + INC_X;
        wrap_o = (sum_x >= MOD_X);
        next_x = wrap_o ? (sum_x - MOD_X) : sum_x;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (srst_i) begin
            phase_q <= '0;
        end else begin
            phase_q <= next_x[W-1:0];
        end
    end

    assign phase_o = phase_q;

    a_r3_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, phase_q} < MOD_X);

    a_r3_grows_without_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i && !wrap_o) |=> (phase_q > $past(phase_q)));

    a_r3_no_growth_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i && wrap_o) |=> (phase_q <= $past(phase_q)));

    a_r6_clear_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i |=> (phase_q == '0));

endmodule

// File: rtl/frac_pulse_reg.sv
module frac_pulse_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic srst_i,
    input  logic wrap_i,
    output logic pulse_o
);

    logic pulse_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap_i && !srst_i;
        end
    end

    assign pulse_o = pulse_q;

    a_r6_clear_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i |=> !pulse_q);

    a_r2_low_in_reset: assert property (@(posedge clk_i)
        !rst_ni |-> !pulse_q);

endmodule

// File: rtl/frac_enable_gen.sv
module frac_enable_gen #(
    parameter int unsigned BASE_HZ = 100_000_000,
    parameter int unsigned OUT_HZ  = 7_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic srst_i,
    output logic pulse_o
);

    localparam int unsigned DIV_G = frac_enable_pkg::gcd_u(BASE_HZ, OUT_HZ);
    localparam int unsigned INC_N = (DIV_G == 0) ? 0 : OUT_HZ / DIV_G;
    localparam int unsigned MOD_M = (DIV_G == 0) ? 1 : BASE_HZ / DIV_G;
    localparam int unsigned W     = frac_enable_pkg::phase_width(MOD_M);

    generate
        if (OUT_HZ == 0 || OUT_HZ > BASE_HZ) begin : g_bad_ratio
            $error("frac_enable_gen: OUT_HZ must lie in 1 .. BASE_HZ");
        end
    endgenerate

    logic         wrap_w;
    logic [W-1:0] phase_w;

    frac_phase_accum #(
        .INC (INC_N),
        .MOD (MOD_M)
    ) accum_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .srst_i  (srst_i),
        .wrap_o  (wrap_w),
        .phase_o (phase_w)
    );

    frac_pulse_reg pulse_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .srst_i  (srst_i),
        .wrap_i  (wrap_w),
        .pulse_o (pulse_o)
    );

    // A pulse only ever follows an edge where the previous phase plus n reached m.
    a_r4_pulse_after_rollover: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> ((32'($past(phase_w)) + INC_N) >= MOD_M));

    generate
        if (INC_N == MOD_M) begin : g_full_rate
            a_r7_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !srst_i |=> pulse_o);
        end
    endgenerate

endmodule

// File: tb/frac_enable_gen_tb.sv
module frac_enable_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic srst = 1'b0;
    logic pa, pb, pc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reduced ratios: a = 7/100, b = 3/8, c = 1/1
    longint ka = 0, kb = 0, kc = 0;

    always #5 clk = ~clk;

    frac_enable_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .pulse_o(pa));

    frac_enable_gen #(.BASE_HZ(48), .OUT_HZ(18)) dut_b_i (
        .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .pulse_o(pb));

    frac_enable_gen #(.BASE_HZ(25), .OUT_HZ(25)) dut_c_i (
        .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .pulse_o(pc));

    function automatic logic exp_pulse(input longint k, input longint n, input longint m);
        if (k == 0) return 1'b0;
        return ((k * n) / m) != (((k - 1) * n) / m);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive srst, take one edge, then compare all three outputs at the falling edge.
    task automatic step(input logic s);
        srst = s;
        @(posedge clk);
        if (s) begin
            ka = 0; kb = 0; kc = 0;
        end else begin
            ka++; kb++; kc++;
        end
        @(negedge clk);
        chk(s ? "R6 clear a" : "R4 pattern 7/100", pa, exp_pulse(ka, 7, 100));
        chk(s ? "R6 clear b" : "R1 pattern 3/8", pb, exp_pulse(kb, 3, 8));
        chk(s ? "R6 clear c" : "R7 full rate", pc, exp_pulse(kc, 1, 1));
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cnt_a;
        int cnt_a2;
        int cnt_b;
        int cnt_b2;
        int cnt_c;
        int dummy;

        // R2: reset state
        repeat (3) @(negedge clk);
        chk("R2 reset a", pa, 0);
        chk("R2 reset b", pb, 0);
        chk("R2 reset c", pc, 0);
        rst_n = 1'b1;

        // R5 and R1: uninterrupted windows
        cnt_a = 0; cnt_a2 = 0; cnt_b = 0; cnt_b2 = 0; cnt_c = 0;
        for (int i = 1; i <= 150; i++) begin
            step(1'b0);
            if (i <= 100) cnt_a += pa;
            if (i > 50) cnt_a2 += pa;
            if (i <= 8) cnt_b += pb;
            if (i >= 5 && i <= 12) cnt_b2 += pb;
            if (i <= 100) cnt_c += pc;
        end
        chk("R5 window 1..100 of 7/100", cnt_a, 7);
        chk("R5 window 51..150 of 7/100", cnt_a2, 7);
        chk("R1 window 1..8 of 3/8", cnt_b, 3);
        chk("R5 window 5..12 of 3/8", cnt_b2, 3);
        chk("R7 window of 1/1", cnt_c, 100);

        // R6: clear at a mid phase, then on a wrap edge of 3/8 (edge 3 wraps)
        step(1'b1);
        step(1'b0); step(1'b0);
        step(1'b1);
        step(1'b0); step(1'b0); step(1'b0);

        // R2: asynchronous reset mid cycle clears at once
        #2 rst_n = 1'b0;
        #1;
        chk("R2 async clear a", pa, 0);
        chk("R2 async clear c", pc, 0);
        @(negedge clk);
        rst_n = 1'b1;
        ka = 0; kb = 0; kc = 0;

        // R3/R4/R6: random clears of random length
        dummy = $urandom(32'd1234);
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 20) == 0) begin
                for (int j = 0; j <= int'($urandom % 3); j++) step(1'b1);
            end else begin
                step(1'b0);
            end
        end

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule